// File: doc/BRIEF.md
# DMA Channel Enable and Status Register File

This block holds the per-channel control and status bits of a multi-channel DMA controller. Each channel has a request-enable bit, a done flag, an interrupt flag and an error flag. A read-only view of the live peripheral request lines is also provided. The transfer engine raises done, interrupt and error by pulsing the matching event input for one cycle. Software clears a flag, or sets or clears an enable bit, by writing a channel number to a command address. Because each command touches only the bit it names, two agents can update different channels without a read-modify-write race on the full mask.

Every software write is a single-cycle strobe on a simple bus port. The channel number is taken from the low byte of the write data, and the upper bits of the write data are not used. Reads are combinational: the selected mask appears zero-extended on the read data port. The enable mask goes straight to the transfer engine. A single interrupt line is raised while any channel's interrupt flag is set.

Top module: `dma_chan_regs`

## Requirements
- R1: A write to address 0x8 with channel index k in wr_data_i[7:0] sets bit k of the enable mask and leaves every other bit unchanged. Bits [31:8] of the write data are ignored.
- R2: A write to address 0x9 with index k clears enable bit k and no other bit.
- R3: Reading address 0x0 returns the enable mask, with bit n belonging to channel n and zeros above bit NUM_CH-1. en_mask_o carries the same mask.
- R4: A one-cycle pulse on int_evt_i[n] sets interrupt flag n, which is read at address 0x2. A write of index n to address 0xA clears flag n only.
- R5: A pulse on done_evt_i[n] sets done flag n, which is read at address 0x1. A write of index n to address 0xB clears that flag only.
- R6: A pulse on err_evt_i[n] sets error flag n, which is read at address 0x3. A write of index n to address 0xC clears that flag only.
- R7: Reading address 0x4 returns hw_req_i in the same cycle, without a register stage.
- R8: When an event pulse and a clear command hit the same flag in the same cycle, the flag ends up set.
- R9: A command whose index byte is NUM_CH or greater changes no bit.
- R10: irq_o is high exactly when at least one interrupt flag is set.
- R11: After reset, all masks read zero, irq_o is low, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one command per cycle |
| wr_addr_i | input | 4 | Command address |
| wr_data_i | input | 32 | Write data; bits [7:0] hold the channel index |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| done_evt_i | input | NUM_CH | Per-channel completion pulse |
| err_evt_i | input | NUM_CH | Per-channel error pulse |
| int_evt_i | input | NUM_CH | Per-channel interrupt pulse |
| hw_req_i | input | NUM_CH | Live peripheral request lines |
| en_mask_o | output | NUM_CH | Request-enable mask |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
The assertions assume that wr_en_i, the addresses and the event inputs are free of X after reset. They also assume that each write is a one-cycle strobe, so the enable mask only moves in a cycle that carries a write. The stimulus changes every input on the falling clock edge and holds each strobe or event for exactly one cycle. The only cycle in which a clear and an event land together is the deliberate test for the rule that set wins.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    RA_EN       = 4'h0,
    RA_DONE     = 4'h1,
    RA_INT      = 4'h2,
    RA_ERR      = 4'h3,
    RA_HWREQ    = 4'h4,
    WA_SET_EN   = 4'h8,
    WA_CLR_EN   = 4'h9,
    WA_CLR_INT  = 4'hA,
    WA_CLR_DONE = 4'hB,
    WA_CLR_ERR  = 4'hC
  } reg_addr_e;
endpackage

// File: rtl/dma_chreg_cmd_dec.sv
module dma_chreg_cmd_dec
  import dma_chreg_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  output logic [NUM_CH-1:0] set_en_o,
  output logic [NUM_CH-1:0] clr_en_o,
  output logic [NUM_CH-1:0] clr_int_o,
  output logic [NUM_CH-1:0] clr_done_o,
  output logic [NUM_CH-1:0] clr_err_o
);
  logic [NUM_CH-1:0] ch_hit;

  // out-of-range indices match no channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign ch_hit[g] = (wr_idx_i == IDX_W'(g));
  end

  always_comb begin
    set_en_o   = (wr_en_i && wr_addr_i == WA_SET_EN)   ? ch_hit : '0;
    clr_en_o   = (wr_en_i && wr_addr_i == WA_CLR_EN)   ? ch_hit : '0;
    clr_int_o  = (wr_en_i && wr_addr_i == WA_CLR_INT)  ? ch_hit : '0;
    clr_done_o = (wr_en_i && wr_addr_i == WA_CLR_DONE) ? ch_hit : '0;
    clr_err_o  = (wr_en_i && wr_addr_i == WA_CLR_ERR)  ? ch_hit : '0;
  end

  assert_idx_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= IDX_W'(NUM_CH)) |->
      ((set_en_o | clr_en_o | clr_int_o | clr_done_o | clr_err_o) == '0));

  assert_single_target_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_en_o | clr_en_o | clr_int_o | clr_done_o | clr_err_o));
endmodule

// File: rtl/dma_chreg_flags.sv
module dma_chreg_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;
      else if (clr_i[g])  q_o[g] <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q_o[g]);

    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !q_o[g]);
  end
endmodule

// File: rtl/dma_chreg_rdmux.sv
module dma_chreg_rdmux
  import dma_chreg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] int_i,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [NUM_CH-1:0] hwreq_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    unique case (rd_addr_i)
      RA_EN:    rd_data_o = DATA_W'(en_i);
      RA_DONE:  rd_data_o = DATA_W'(done_i);
      RA_INT:   rd_data_o = DATA_W'(int_i);
      RA_ERR:   rd_data_o = DATA_W'(err_i);
      RA_HWREQ: rd_data_o = DATA_W'(hwreq_i);
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chreg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic [NUM_CH-1:0] int_evt_i,
  input  logic [NUM_CH-1:0] hw_req_i,
  output logic [NUM_CH-1:0] en_mask_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] set_en, clr_en, clr_int, clr_done, clr_err;
  logic [NUM_CH-1:0] done_q, int_q, err_q;

  dma_chreg_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i,
    .wr_idx_i   (wr_data_i[IDX_W-1:0]),
    .set_en_o   (set_en),
    .clr_en_o   (clr_en),
    .clr_int_o  (clr_int),
    .clr_done_o (clr_done),
    .clr_err_o  (clr_err)
  );

  dma_chreg_flags #(.W(NUM_CH)) u_en (
    .clk_i, .rst_ni, .set_i(set_en), .clr_i(clr_en), .q_o(en_mask_o));
  dma_chreg_flags #(.W(NUM_CH)) u_done (
    .clk_i, .rst_ni, .set_i(done_evt_i), .clr_i(clr_done), .q_o(done_q));
  dma_chreg_flags #(.W(NUM_CH)) u_int (
    .clk_i, .rst_ni, .set_i(int_evt_i), .clr_i(clr_int), .q_o(int_q));
  dma_chreg_flags #(.W(NUM_CH)) u_err (
    .clk_i, .rst_ni, .set_i(err_evt_i), .clr_i(clr_err), .q_o(err_q));

  dma_chreg_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .rd_addr_i, .en_i(en_mask_o), .done_i(done_q), .int_i(int_q),
    .err_i(err_q), .hwreq_i(hw_req_i), .rd_data_o);

  assign irq_o = |int_q;

  assert_en_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_mask_o));

  assert_irq_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|int_evt_i));

  assert_irq_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && wr_addr_i == WA_CLR_INT));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int NUM_CH = 8;
  localparam int DATA_W = 32;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [3:0] addr;
    logic [7:0] idx;
    logic [7:0] exp;
  } vec_t;

  // enable-mask command sequence: R1 sets, R2 clears, R9 out-of-range
  localparam vec_t VECS [8] = '{
    '{4'h8, 8'd0,   8'h01},
    '{4'h8, 8'd5,   8'h21},
    '{4'h8, 8'd7,   8'hA1},
    '{4'h8, 8'd9,   8'hA1},
    '{4'h9, 8'd5,   8'h81},
    '{4'h8, 8'd0,   8'h81},
    '{4'h9, 8'd200, 8'h81},
    '{4'h9, 8'd0,   8'h80}
  };

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [DATA_W-1:0] wr_data = 0, rd_data;
  logic [NUM_CH-1:0] done_evt = 0, err_evt = 0, int_evt = 0, hw_req = 0, en_mask;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_chan_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .done_evt_i(done_evt), .err_evt_i(err_evt), .int_evt_i(int_evt),
    .hw_req_i(hw_req), .en_mask_o(en_mask), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(int which, int ch);
    @(negedge clk);
    case (which)
      0: done_evt[ch] = 1;
      1: err_evt[ch]  = 1;
      default: int_evt[ch] = 1;
    endcase
    @(negedge clk);
    done_evt = 0; err_evt = 0; int_evt = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d); check("R11", d, 0);
    end
    check("R11 irq", {31'b0, irq}, 0);

    // R1/R2/R9 table walk, R3 mirror
    foreach (VECS[i]) begin
      wr(VECS[i].addr, {24'h0, VECS[i].idx});
      rd(4'h0, d);
      check("R3 read", d, {24'h0, VECS[i].exp});
      check("R1/R2 en_mask_o", {24'h0, en_mask}, {24'h0, VECS[i].exp});
    end

    // R1 upper write-data bits ignored
    wr(4'h8, 32'hFFFF_FF03);
    rd(4'h0, d); check("R1 upper bits", d, 32'h88);

    // R7 live request view
    hw_req = 8'h5A; rd(4'h4, d); check("R7", d, 32'h5A);
    hw_req = 8'h81; rd(4'h4, d); check("R7", d, 32'h81);
    hw_req = 0;

    // R4 interrupt flags, R10 irq
    pulse(2, 1); pulse(2, 6);
    rd(4'h2, d); check("R4 set", d, 32'h42);
    check("R10 irq high", {31'b0, irq}, 1);
    wr(4'hA, 32'd1);
    rd(4'h2, d); check("R4 clear one", d, 32'h40);
    check("R10 irq still high", {31'b0, irq}, 1);
    wr(4'hA, 32'd8);  // R9 out of range
    rd(4'h2, d); check("R9 int", d, 32'h40);
    wr(4'hA, 32'd6);
    rd(4'h2, d); check("R4 clear last", d, 32'h0);
    check("R10 irq low", {31'b0, irq}, 0);

    // R5 done flags
    pulse(0, 3); pulse(0, 7);
    rd(4'h1, d); check("R5 set", d, 32'h88);
    wr(4'hB, 32'd7);
    rd(4'h1, d); check("R5 clear", d, 32'h08);

    // R6 error flags
    pulse(1, 0); pulse(1, 4);
    rd(4'h3, d); check("R6 set", d, 32'h11);
    wr(4'hC, 32'd0);
    rd(4'h3, d); check("R6 clear", d, 32'h10);
    rd(4'h1, d); check("R6 done untouched", d, 32'h08);

    // R8 set wins over same-cycle clear
    @(negedge clk);
    int_evt[2] = 1; wr_en = 1; wr_addr = 4'hA; wr_data = 32'd2;
    @(negedge clk);
    int_evt = 0; wr_en = 0;
    rd(4'h2, d); check("R8 set wins", d, 32'h04);
    check("R8 irq", {31'b0, irq}, 1);

    // R11 unmapped read, R3 mask still intact
    rd(4'h7, d); check("R11 unmapped", d, 0);
    rd(4'h0, d); check("R3 final", d, 32'h88);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule